// File: doc/BRIEF.md
# Tag-Routed Two-by-Two Interchange Switch

This block is one switching element of a circuit-switched multistage cube network in which every message routes itself. Each of its two inputs, upper (index 0) and lower (index 1), carries a data word with parity, a request line, a forward data-available strobe, and returned grant and data-received lines. When a request arrives, the element reads one destination bit and one broadcast bit from the routing word, which is the first word of the message. It then connects the input to the upper output, the lower output, or both.

A connection is held for as long as the request line stays high. While it is held, later words are treated as payload and pass through without being decoded. Requests that find their output taken are blocked until the source gives up and tries again. When a connection drives both outputs, the two returned handshakes are combined so that a failure on either branch reaches the source.

Top module: `tag_xbar2`

## Requirements
- R1: With parameter STAGE = s, routing uses only word bit TAG_LSB+s as the tag bit and word bit MASK_LSB+s as the mask bit. With the defaults (TAG_LSB=0, MASK_LSB=8, STAGE=2), these are bits 2 and 10, and every other word bit has no effect on routing.
- R2: A request with mask bit 0 goes to output 0 (upper) when the tag bit is 0 and to output 1 (lower) when the tag bit is 1. The connection is in force from the first clock edge that sees the request.
- R3: A request with mask bit 1 claims both outputs. Its word, parity, request and data-available lines appear on both outputs.
- R4: While a connection is held, the input's word and parity appear on the claimed outputs in the same cycle. Payload bits never change the routing.
- R5: When the request of a connected input goes low, its outputs are released at the next edge. A request raised in the cycle after that edge can claim them.
- R6: A request that needs an output already claimed by the other input is blocked. Blocking applies to a single output or to either output for a broadcast. The blocked input sees grant 0 and receives no output.
- R7: When both inputs request conflicting outputs at the same edge, the upper input is connected and the lower input is blocked.
- R8: A blocked input stays blocked for as long as its request stays high, even after the output it wanted becomes free. It is served only after its request goes low and rises again.
- R9: The returned signals are combined over all outputs the input holds. Grant (active high) is 1 only when every held output's grant is 1. Data-received (active low) is 0 only when every held output's data-received is 0. An input with no connection sees grant 0 and data-received 1.
- R10: The active-low data-available strobe of a connected input is forwarded to its claimed outputs. An unclaimed output drives request 0, data-available 1, and zero word and parity.
- R11: After reset, no output is claimed, both grants are 0, and both data-received returns are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 2 | Request per input (bit 0 upper) |
| in_word | input | 2 x DATA_W | Data word per input; first word routes |
| in_par | input | 2 x PAR_W | Parity per input |
| in_avail_n | input | 2 | Active-low data-available strobe per input |
| in_grant | output | 2 | Grant returned to each input |
| in_rcvd_n | output | 2 | Active-low data-received returned to each input |
| out_req | output | 2 | Request per output (bit 0 upper) |
| out_word | output | 2 x DATA_W | Data word per output |
| out_par | output | 2 x PAR_W | Parity per output |
| out_avail_n | output | 2 | Active-low data-available per output |
| out_grant | input | 2 | Grant from downstream per output |
| out_rcvd_n | input | 2 | Active-low data-received from downstream per output |

## Verification
Two kinds of event can fall on the same clock edge. The first is a new claim by one input against a claim by the other, either a fresh one or one already held. The second is a release by one input while the other input still holds a request it was refused. Both inputs are raised in the same cycle toward the same output, and a broadcast is raised against a single held output. Each case is judged by which grant rises and which output lines carry the winner's word. A refused input is kept high across the winner's release to show that it is not served without a fresh request.

// File: rtl/tag_xbar2_pkg.sv
package tag_xbar2_pkg;
   typedef enum logic [1:0] {
      PS_IDLE  = 2'd0,
      PS_CONN  = 2'd1,
      PS_BLOCK = 2'd2
   } port_state_e;

   localparam int unsigned NPORT = 2;
endpackage

// File: rtl/tag_xbar2_decode.sv
module tag_xbar2_decode #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned TAG_LSB  = 0,
   parameter int unsigned MASK_LSB = 8,
   parameter int unsigned STAGE    = 2
) (
   input  logic [DATA_W-1:0] word,
   output logic [1:0]        need
);
   localparam int unsigned TAG_POS  = TAG_LSB + STAGE;
   localparam int unsigned MASK_POS = MASK_LSB + STAGE;

   always_comb begin
      if (word[MASK_POS])     need = 2'b11;
      else if (word[TAG_POS]) need = 2'b10;
      else                    need = 2'b01;
   end
endmodule

// File: rtl/tag_xbar2_port.sv
module tag_xbar2_port
   import tag_xbar2_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic [1:0] need,
   input  logic       win,
   output logic       start,
   output logic [1:0] own,
   output logic       conn
);
   port_state_e st_q;
   logic [1:0]  own_q;

   assign start = (st_q == PS_IDLE) && req;
   assign own   = own_q;
   assign conn  = (st_q == PS_CONN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= PS_IDLE;
         own_q <= 2'b00;
      end else begin
         unique case (st_q)
            PS_IDLE: if (req) begin
               if (win) begin
                  st_q  <= PS_CONN;
                  own_q <= need;
               end else begin
                  st_q  <= PS_BLOCK;
               end
            end
            PS_CONN: if (!req) begin
               st_q  <= PS_IDLE;
               own_q <= 2'b00;
            end
            PS_BLOCK: if (!req) st_q <= PS_IDLE;
            default: begin
               st_q  <= PS_IDLE;
               own_q <= 2'b00;
            end
         endcase
      end
   end

   // R5: dropping the request tears the path down at the next edge
   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      (conn && !req) |=> (own == 2'b00));
   // R4: payload cycles never alter the held routing
   a_r4_route_held: assert property (@(posedge clk) disable iff (!rst_n)
      (conn && req) |=> $stable(own));
   // R8: a refused request stays refused while held high
   a_r8_stay_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == PS_BLOCK) && req) |=> (!conn && own == 2'b00));
endmodule

// File: rtl/tag_xbar2_lane.sv
module tag_xbar2_lane #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned PAR_W  = 2
) (
   input  logic                   taken,
   input  logic                   src,
   input  logic [1:0]             in_req,
   input  logic [1:0][DATA_W-1:0] in_word,
   input  logic [1:0][PAR_W-1:0]  in_par,
   input  logic [1:0]             in_avail_n,
   output logic                   o_req,
   output logic [DATA_W-1:0]      o_word,
   output logic [PAR_W-1:0]       o_par,
   output logic                   o_avail_n
);
   always_comb begin
      if (taken) begin
         o_req     = in_req[src];
         o_word    = in_word[src];
         o_par     = in_par[src];
         o_avail_n = in_avail_n[src];
      end else begin
         o_req     = 1'b0;
         o_word    = '0;
         o_par     = '0;
         o_avail_n = 1'b1;
      end
   end
endmodule

// File: rtl/tag_xbar2.sv
module tag_xbar2
   import tag_xbar2_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned PAR_W    = 2,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned TAG_LSB  = 0,
   parameter int unsigned MASK_LSB = 8,
   parameter int unsigned STAGE    = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             in_req,
   input  logic [1:0][DATA_W-1:0] in_word,
   input  logic [1:0][PAR_W-1:0]  in_par,
   input  logic [1:0]             in_avail_n,
   output logic [1:0]             in_grant,
   output logic [1:0]             in_rcvd_n,
   output logic [1:0]             out_req,
   output logic [1:0][DATA_W-1:0] out_word,
   output logic [1:0][PAR_W-1:0]  out_par,
   output logic [1:0]             out_avail_n,
   input  logic [1:0]             out_grant,
   input  logic [1:0]             out_rcvd_n
);
   localparam int unsigned TAG_TOP  = TAG_LSB + ADDR_W - 1;
   localparam int unsigned MASK_TOP = MASK_LSB + ADDR_W - 1;

   generate
      if (STAGE >= ADDR_W)   begin : g_bad_stage $error("STAGE outside address width"); end
      if (TAG_TOP >= DATA_W)  begin : g_bad_tag   $error("tag field beyond word"); end
      if (MASK_TOP >= DATA_W) begin : g_bad_mask  $error("mask field beyond word"); end
      if (PAR_W == 0)         begin : g_bad_par   $error("PAR_W must be nonzero"); end
   endgenerate

   logic [1:0][1:0] need;
   logic [1:0][1:0] own;
   logic [1:0]      start;
   logic [1:0]      conn;
   logic [1:0]      win;
   logic [1:0]      busy;
   logic [1:0]      up_claim;

   assign busy     = own[0] | own[1];
   assign up_claim = (start[0] && win[0]) ? need[0] : 2'b00;
   assign win[0]   = ~|(need[0] & busy);
   assign win[1]   = ~|(need[1] & (busy | up_claim));

   genvar gi;
   generate
      for (gi = 0; gi < NPORT; gi++) begin : g_in
         tag_xbar2_decode #(
            .DATA_W(DATA_W), .TAG_LSB(TAG_LSB), .MASK_LSB(MASK_LSB), .STAGE(STAGE)
         ) u_dec (
            .word(in_word[gi]),
            .need(need[gi])
         );

         tag_xbar2_port u_port (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (in_req[gi]),
            .need (need[gi]),
            .win  (win[gi]),
            .start(start[gi]),
            .own  (own[gi]),
            .conn (conn[gi])
         );

         assign in_grant[gi]  = conn[gi] & (&(out_grant | ~own[gi]));
         assign in_rcvd_n[gi] = conn[gi] ? (|(out_rcvd_n & own[gi])) : 1'b1;
      end

      for (gi = 0; gi < NPORT; gi++) begin : g_out
         tag_xbar2_lane #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_lane (
            .taken     (busy[gi]),
            .src       (own[1][gi]),
            .in_req    (in_req),
            .in_word   (in_word),
            .in_par    (in_par),
            .in_avail_n(in_avail_n),
            .o_req     (out_req[gi]),
            .o_word    (out_word[gi]),
            .o_par     (out_par[gi]),
            .o_avail_n (out_avail_n[gi])
         );
      end
   endgenerate

   // R6: an output never belongs to both inputs
   a_r6_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (own[0] & own[1]) == 2'b00);
   // R7: same-edge conflict is resolved toward the upper input
   a_r7_upper_first: assert property (@(posedge clk) disable iff (!rst_n)
      (start[0] && start[1] && busy == 2'b00 && |(need[0] & need[1]))
      |=> (conn[0] && !conn[1]));
   // R2: an uncontested straight-up request lands on output 0 only
   a_r2_upper_route: assert property (@(posedge clk) disable iff (!rst_n)
      (start[0] && busy == 2'b00 && need[0] == 2'b01) |=> (own[0] == 2'b01));
   // R10: an unclaimed output stays quiet
   a_r10_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[0] == 1'b0) |-> (out_req[0] == 1'b0 && out_avail_n[0] == 1'b1));
endmodule

// File: tb/tag_xbar2_bench.sv
module tag_xbar2_bench;
   localparam int unsigned DW = 16;
   localparam int unsigned PW = 2;

   logic clk = 1'b0;
   logic rst_n;
   logic [1:0]         in_req;
   logic [1:0][DW-1:0] in_word;
   logic [1:0][PW-1:0] in_par;
   logic [1:0]         in_avail_n;
   logic [1:0]         in_grant;
   logic [1:0]         in_rcvd_n;
   logic [1:0]         out_req;
   logic [1:0][DW-1:0] out_word;
   logic [1:0][PW-1:0] out_par;
   logic [1:0]         out_avail_n;
   logic [1:0]         out_grant;
   logic [1:0]         out_rcvd_n;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   tag_xbar2 u_tag_xbar2 (
      .clk(clk), .rst_n(rst_n),
      .in_req(in_req), .in_word(in_word), .in_par(in_par), .in_avail_n(in_avail_n),
      .in_grant(in_grant), .in_rcvd_n(in_rcvd_n),
      .out_req(out_req), .out_word(out_word), .out_par(out_par), .out_avail_n(out_avail_n),
      .out_grant(out_grant), .out_rcvd_n(out_rcvd_n)
   );

   // routing word for stage 2: tag bit 2, mask bit 10, junk elsewhere
   function automatic logic [DW-1:0] rw(input logic tag, input logic msk);
      return 16'hFBFB | (16'(tag) << 2) | (16'(msk) << 10);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic idle_all();
      in_req = 2'b00;
      step();
      step();
   endtask

   task automatic t_reset();
      chk("R11 grant", 32'(in_grant), 32'h0);
      chk("R11 rcvd_n", 32'(in_rcvd_n), 32'h3);
      chk("R11 out_req", 32'(out_req), 32'h0);
      chk("R10 idle avail_n", 32'(out_avail_n), 32'h3);
   endtask

   task automatic t_straight();
      in_word[0] = rw(1'b0, 1'b0); in_par[0] = 2'b10; in_req[0] = 1'b1;
      step();
      chk("R2 upper grant", 32'(in_grant), 32'h1);
      chk("R2 upper out_req", 32'(out_req), 32'h1);
      chk("R1 junk ignored, word on out0", 32'(out_word[0]), 32'(rw(1'b0, 1'b0)));
      chk("R10 unclaimed word zero", 32'(out_word[1]), 32'h0);
      in_word[0] = 16'h0404; in_par[0] = 2'b01; in_avail_n[0] = 1'b0;
      #1;
      chk("R4 payload pass", 32'(out_word[0]), 32'h0404);
      chk("R4 parity pass", 32'(out_par[0]), 32'h1);
      chk("R10 avail forward", 32'(out_avail_n), 32'h2);
      step();
      chk("R4 route held", 32'(out_req), 32'h1);
      out_rcvd_n = 2'b10;
      #1;
      chk("R9 rcvd single branch", 32'(in_rcvd_n), 32'h2);
      out_rcvd_n = 2'b11; in_avail_n = 2'b11;
      in_req[0] = 1'b0;
      step();
      chk("R5 released grant", 32'(in_grant), 32'h0);
      idle_all();
   endtask

   task automatic t_exchange();
      in_word[0] = rw(1'b1, 1'b0); in_word[1] = rw(1'b0, 1'b0);
      in_req = 2'b11;
      step();
      chk("R2 both granted", 32'(in_grant), 32'h3);
      in_word[0] = 16'hA5A5; in_word[1] = 16'h5A5A;
      #1;
      chk("R2 in0 to lower", 32'(out_word[1]), 32'hA5A5);
      chk("R2 in1 to upper", 32'(out_word[0]), 32'h5A5A);
      idle_all();
   endtask

   task automatic t_broadcast();
      in_word[1] = rw(1'b1, 1'b1); in_req[1] = 1'b1;
      step();
      chk("R3 bcast out_req", 32'(out_req), 32'h3);
      in_word[1] = 16'h1234;
      #1;
      chk("R3 copy out0", 32'(out_word[0]), 32'h1234);
      chk("R3 copy out1", 32'(out_word[1]), 32'h1234);
      chk("R9 grant both", 32'(in_grant), 32'h2);
      out_grant = 2'b10;
      #1;
      chk("R9 grant AND", 32'(in_grant), 32'h0);
      out_grant = 2'b11; out_rcvd_n = 2'b10;
      #1;
      chk("R9 rcvd one branch", 32'(in_rcvd_n[1]), 32'h1);
      out_rcvd_n = 2'b00;
      #1;
      chk("R9 rcvd both", 32'(in_rcvd_n[1]), 32'h0);
      out_rcvd_n = 2'b11;
      idle_all();
   endtask

   task automatic t_held_conflict();
      in_word[0] = rw(1'b0, 1'b0); in_req[0] = 1'b1;
      step();
      in_word[1] = rw(1'b0, 1'b0); in_req[1] = 1'b1;
      step();
      chk("R6 blocked grant", 32'(in_grant), 32'h1);
      chk("R6 no lower path", 32'(out_req), 32'h1);
      in_req[0] = 1'b0;
      step();
      step();
      chk("R8 still blocked", 32'(in_grant), 32'h0);
      chk("R8 no output", 32'(out_req), 32'h0);
      in_req[1] = 1'b0;
      step();
      in_req[1] = 1'b1;
      step();
      chk("R8 retry served", 32'(in_grant), 32'h2);
      idle_all();
   endtask

   task automatic t_same_edge();
      in_word[0] = rw(1'b1, 1'b0); in_word[1] = rw(1'b1, 1'b0);
      in_req = 2'b11;
      step();
      chk("R7 upper wins", 32'(in_grant), 32'h1);
      chk("R7 lower output to in0", 32'(out_word[1]), 32'(rw(1'b1, 1'b0)));
      idle_all();
   endtask

   task automatic t_bcast_blocked();
      in_word[0] = rw(1'b1, 1'b0); in_req[0] = 1'b1;
      step();
      in_word[1] = rw(1'b0, 1'b1); in_req[1] = 1'b1;
      step();
      chk("R6 bcast blocked", 32'(in_grant), 32'h1);
      chk("R6 upper left idle", 32'(out_req), 32'h2);
      idle_all();
   endtask

   task automatic t_reuse();
      in_word[0] = rw(1'b0, 1'b0); in_req[0] = 1'b1;
      step();
      in_req[0] = 1'b0;
      step();
      in_word[1] = rw(1'b0, 1'b0); in_req[1] = 1'b1;
      step();
      chk("R5 freed output reused", 32'(in_grant), 32'h2);
      chk("R5 out0 from in1", 32'(out_req), 32'h1);
      idle_all();
   endtask

   initial begin
      rst_n = 1'b0;
      in_req = 2'b00; in_word = '0; in_par = '0; in_avail_n = 2'b11;
      out_grant = 2'b11; out_rcvd_n = 2'b11;
      step(); step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_straight();
      t_exchange();
      t_broadcast();
      t_held_conflict();
      t_same_edge();
      t_bcast_blocked();
      t_reuse();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule